// File: doc/BRIEF.md
# Supervisor Reset and Watchdog Controller

This block generates a single system reset from three causes: power-on, a low supply, and a watchdog that has not been serviced. The supply state arrives as a synchronous "supply above threshold" flag from an external comparator. The watchdog is serviced through the chip-select pin. Only a high-to-low transition of that pin restarts the watchdog. A pin held at either level times out once the selected period has passed.

Every cause feeds one shared hold timer. The reset stays asserted while any cause is present. It is released only after no cause has been present for a fixed number of timebase ticks. A clock-cycle prescaler generates the timebase ticks. All time constants are parameters, so a simulation can use short values. A 2-bit period selection picks one of three watchdog intervals or turns the watchdog off. A polarity input selects an active-high or an active-low output.

Top module: `rst_supervisor`

## Requirements
- R1: While `arst_n` is low (power-up), the reset output is asserted. The asserted level is 1 when `active_high`=1 and 0 when `active_high`=0. The deasserted level is the inverse.
- R2: After power-up with the supply flag high, reset releases once HOLD_TICKS timebase ticks have elapsed. That is between (HOLD_TICKS-1)·TICK_CYCLES+1 and HOLD_TICKS·TICK_CYCLES clock cycles after `arst_n` rises.
- R3: A low `supply_ok` asserts reset at the next clock edge.
- R4: Any dip of `supply_ok` during the hold interval restarts the hold count from zero.
- R5: Falling edges on `cs_n_pin` that arrive more often than the selected period keep reset deasserted.
- R6: When `cs_n_pin` stays high, or stays low, for longer than the selected period, reset asserts.
- R7: A rising edge on `cs_n_pin` does not restart the watchdog.
- R8: `wd_sel` selects the period as follows: 00 gives WD_LONG_TICKS, 01 gives WD_MID_TICKS, 10 gives WD_SHORT_TICKS, and 11 disables the watchdog.
- R9: A watchdog timeout holds reset for the same HOLD_TICKS interval. The watchdog count restarts from zero when reset deasserts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| arst_n | input | 1 | Asynchronous power-on reset, active low |
| supply_ok | input | 1 | Synchronous flag, 1 = supply above trip level |
| cs_n_pin | input | 1 | Chip-select pin, also the watchdog service input (asynchronous) |
| wd_sel | input | 2 | Watchdog period select (00 long, 01 mid, 10 short, 11 off) |
| active_high | input | 1 | Output polarity: 1 = active-high reset, 0 = active-low |
| sys_rst | output | 1 | System reset output |

## Verification
The chip-select pin is driven with five patterns. Regular falling edges separate a serviced watchdog from a stuck one. A pin held high and a pin held low show that both levels time out. A pin held low with a single rising edge midway shows that rising edges are not treated as service. With the watchdog disabled, no timeout may occur over a long window. The supply flag is driven with a single-cycle dip and with a second dip during the hold. Together these separate a hold that restarts from one that only continues. Each period encoding and both polarities are measured against their cycle windows, so any swap of interval encodings is caught.

// File: rtl/rst_supervisor.sv
module rst_supervisor #(
  parameter int TICK_CYCLES    = 125000,
  parameter int HOLD_TICKS     = 200,
  parameter int WD_LONG_TICKS  = 1400,
  parameter int WD_MID_TICKS   = 600,
  parameter int WD_SHORT_TICKS = 200
) (
  input  logic       clk,
  input  logic       arst_n,
  input  logic       supply_ok,
  input  logic       cs_n_pin,
  input  logic [1:0] wd_sel,
  input  logic       active_high,
  output logic       sys_rst
);
  localparam int PW = $clog2(TICK_CYCLES + 1);
  localparam int HW = $clog2(HOLD_TICKS + 1);
  localparam int WW = $clog2(WD_LONG_TICKS + 1);

  logic [PW-1:0] pre_cnt;
  logic [HW-1:0] hold_cnt;
  logic [WW-1:0] wd_cnt, wd_limit;
  logic [2:0]    cs_sync;
  logic          in_rst, tick, cs_fall, wd_on, wd_fire, cause;

  assign tick    = (pre_cnt == PW'(TICK_CYCLES - 1));
  assign cs_fall = cs_sync[2] & ~cs_sync[1];
  assign wd_on   = (wd_sel != 2'b11);

  always_comb begin
    case (wd_sel)
      2'b00:   wd_limit = WW'(WD_LONG_TICKS);
      2'b01:   wd_limit = WW'(WD_MID_TICKS);
      default: wd_limit = WW'(WD_SHORT_TICKS);
    endcase
  end

  assign wd_fire = wd_on & ~in_rst & ~cs_fall & tick & (wd_cnt == wd_limit - 1'b1);
  assign cause   = ~supply_ok | wd_fire;
  assign sys_rst = active_high ? in_rst : ~in_rst;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      pre_cnt <= '0;
      cs_sync <= 3'b111;
    end else begin
      pre_cnt <= tick ? '0 : pre_cnt + 1'b1;
      cs_sync <= {cs_sync[1:0], cs_n_pin};
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      in_rst   <= 1'b1;
      hold_cnt <= '0;
    end else if (cause) begin
      in_rst   <= 1'b1;
      hold_cnt <= '0;
    end else if (in_rst && tick) begin
      if (hold_cnt == HW'(HOLD_TICKS - 1)) begin
        in_rst   <= 1'b0;
        hold_cnt <= '0;
      end else begin
        hold_cnt <= hold_cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)
      wd_cnt <= '0;
    else if (in_rst || !wd_on || cs_fall || wd_fire)
      wd_cnt <= '0;
    else if (tick)
      wd_cnt <= wd_cnt + 1'b1;
  end
endmodule

module rst_supervisor_chk #(
  parameter int HW = 8,
  parameter int WW = 11,
  parameter int HOLD_TICKS = 200
) (
  input logic          clk,
  input logic          arst_n,
  input logic          supply_ok,
  input logic [1:0]    wd_sel,
  input logic          active_high,
  input logic          sys_rst,
  input logic          in_rst,
  input logic [HW-1:0] hold_cnt,
  input logic [WW-1:0] wd_cnt
);
  a_r3_low_supply_resets: assert property (@(posedge clk) disable iff (!arst_n)
    (!supply_ok && $stable(active_high)) |=> (sys_rst == active_high));
  a_r2_release_needs_supply: assert property (@(posedge clk) disable iff (!arst_n)
    $fell(in_rst) |-> $past(supply_ok));
  a_r4_hold_in_range: assert property (@(posedge clk) disable iff (!arst_n)
    hold_cnt < HW'(HOLD_TICKS));
  a_r9_wd_idle_in_reset: assert property (@(posedge clk) disable iff (!arst_n)
    in_rst |=> (wd_cnt == '0));
  a_r8_off_no_count: assert property (@(posedge clk) disable iff (!arst_n)
    (wd_sel == 2'b11) |=> (wd_cnt == '0));
endmodule

bind rst_supervisor rst_supervisor_chk #(.HW(HW), .WW(WW), .HOLD_TICKS(HOLD_TICKS)) u_chk (
  .clk(clk), .arst_n(arst_n), .supply_ok(supply_ok), .wd_sel(wd_sel),
  .active_high(active_high), .sys_rst(sys_rst), .in_rst(in_rst),
  .hold_cnt(hold_cnt), .wd_cnt(wd_cnt));

// File: tb/tb_rst_supervisor.sv
`timescale 1ns/1ps
module tb_rst_supervisor;
  localparam int T = 4, HOLD = 10, WL = 40, WM = 20, WS = 8;
  logic clk = 0, arst_n = 0, supply_ok = 1, cs_n_pin = 1, active_high = 1;
  logic [1:0] wd_sel = 2'b11;
  logic sys_rst;
  int n_chk = 0, n_fail = 0;

  rst_supervisor #(.TICK_CYCLES(T), .HOLD_TICKS(HOLD), .WD_LONG_TICKS(WL),
                   .WD_MID_TICKS(WM), .WD_SHORT_TICKS(WS)) dut (
    .clk(clk), .arst_n(arst_n), .supply_ok(supply_ok), .cs_n_pin(cs_n_pin),
    .wd_sel(wd_sel), .active_high(active_high), .sys_rst(sys_rst));

  always #4 clk = ~clk;

  function automatic logic asserted();
    return sys_rst == active_high;
  endfunction

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic measure(input logic target, input int maxc, output int n);
    n = 0;
    while (asserted() != target && n < maxc) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic power_up(input logic pol, input logic [1:0] sel);
    arst_n = 0; active_high = pol; wd_sel = sel; supply_ok = 1;
    cyc(2);
    arst_n = 1;
  endtask

  task automatic t_por();
    int n;
    power_up(1'b1, 2'b11);
    chk(sys_rst == 1'b1, "R1 reset level high polarity", sys_rst, 1);
    measure(1'b0, 200, n);
    chk(n >= HOLD*T-4 && n <= HOLD*T+2, "R2 power-up release cycles", n, HOLD*T);
  endtask

  task automatic t_polarity();
    int n;
    power_up(1'b0, 2'b11);
    chk(sys_rst == 1'b0, "R1 reset level low polarity", sys_rst, 0);
    measure(1'b0, 200, n);
    chk(sys_rst == 1'b1, "R1 released level low polarity", sys_rst, 1);
  endtask

  task automatic t_brownout();
    int n, m;
    supply_ok = 0; cyc(1); supply_ok = 1;
    chk(asserted(), "R3 low supply asserts next edge", asserted(), 1);
    cyc(20);
    chk(asserted(), "R4 still in hold", asserted(), 1);
    supply_ok = 0; cyc(1); supply_ok = 1;
    measure(1'b0, 200, n);
    chk(n >= HOLD*T-4 && n <= HOLD*T+2, "R4 hold restarted after dip", n, HOLD*T);
    m = n + 21;
    chk(m > HOLD*T+3, "R4 total hold exceeds single interval", m, HOLD*T+20);
  endtask

  task automatic wd_timeout(input logic [1:0] sel, input int lim, input string req);
    int n;
    power_up(1'b1, sel);
    measure(1'b0, 300, n);
    measure(1'b1, lim*T+60, n);
    chk(n >= lim*T-4 && n <= lim*T+2, req, n, lim*T);
  endtask

  task automatic t_kick();
    int n;
    power_up(1'b1, 2'b10);
    measure(1'b0, 200, n);
    n = 0;
    for (int i = 0; i < 16; i++) begin
      cs_n_pin = 0; cyc(8);
      cs_n_pin = 1; cyc(8);
      if (asserted()) n++;
    end
    chk(n == 0, "R5 regular falling edges keep reset off", n, 0);
  endtask

  task automatic t_stuck_low_rise();
    int n;
    cs_n_pin = 0;
    power_up(1'b1, 2'b10);
    measure(1'b0, 200, n);
    cyc(16);
    chk(!asserted(), "R6 no early timeout stuck low", asserted(), 0);
    cs_n_pin = 1;
    measure(1'b1, 100, n);
    n += 16;
    chk(n >= WS*T-4 && n <= WS*T+2, "R7 rising edge does not restart", n, WS*T);
  endtask

  task automatic t_wd_hold_restart();
    int n;
    cs_n_pin = 1;
    wd_timeout(2'b10, WS, "R6 stuck high timeout short");
    measure(1'b0, 200, n);
    chk(n >= HOLD*T-4 && n <= HOLD*T+2, "R9 timeout reset held for hold time", n, HOLD*T);
    measure(1'b1, 200, n);
    chk(n >= WS*T-4 && n <= WS*T+2, "R9 watchdog restarts from zero", n, WS*T);
  endtask

  task automatic t_disabled();
    int n;
    power_up(1'b1, 2'b11);
    measure(1'b0, 200, n);
    measure(1'b1, 500, n);
    chk(n == 500, "R8 disabled watchdog never fires", n, 500);
  endtask

  initial begin
    #2000000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    cyc(1);
    t_por();
    t_polarity();
    active_high = 1;
    t_brownout();
    t_wd_hold_restart();
    t_stuck_low_rise();
    t_kick();
    cs_n_pin = 1;
    wd_timeout(2'b01, WM, "R8 mid period 01");
    wd_timeout(2'b00, WL, "R8 long period 00");
    t_disabled();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule